// File: doc/BRIEF.md
# NAND Raw Bus Cycle Generator

This block converts single host accesses into one parallel NAND bus cycle each. The host presents a request with an address and, for writes, a byte. The low byte of the address selects a port: a command port, an address port or a data port. The two bits above it select one of up to four chip enables. The block then drives the command latch enable, the address latch enable, the write and read strobes, the active-low chip enables and the data bus. The data bus is split into an output, an output enable and an input, so a pad ring can build the bidirectional pin from them.

All phase lengths come from two timing words, each made of four tick counts. One word serves write cycles and the other serves read cycles. A tick count is counted in clocks of the block. Both words are captured when a request is accepted. While a cycle is in progress the block reports busy, and it takes no new request. The flash ready/busy pin passes through a synchronizer and shows up as the top bit of a 32-bit status word.

Top module: `nand_cycle_gen`

## Requirements
- R1: A write with address bits [7:0] = 0x00 makes a cycle with CLE high. A write with address bits [7:0] = 0x04 makes a cycle with ALE high. An access at address bits [7:0] = 0x08 makes a data write or a data read cycle, with CLE and ALE both low. CLE and ALE are never high together.
- R2: Address bits [9:8] pick the chip enable. During an access only that bit of `nand_ce_n` is low. When the block is idle, every bit is high.
- R3: The write timing word is split into four fields: [31:24] setup, [23:16] extension, [15:8] cycle, [7:0] strobe. A command, address or data write has four phases. First, CE#, CLE, ALE and the data are held for `setup` clocks with both strobes high. Next, WE# is low for `strobe` clocks. Then WE# is high for `cycle - strobe` clocks, or for 1 clock when `cycle <= strobe`. Last comes an extension of `extension` clocks.
- R4: The read timing word is split into four fields: [31:24] access, [23:16] hold, [15:8] unused, [7:0] release. A data read has a setup of the write word's [31:24] clocks, followed by RE# low for `access` clocks. `nand_dq_in` is captured on the last of those clocks and `rd_valid` pulses once. After that, RE# stays high for `hold + release` clocks.
- R5: A tick field of 0 behaves like 1, so every phase lasts at least one clock.
- R6: `nand_dq_oe` is high during the whole of a write access and low during the whole of a read access. `nand_dq_out` carries the written byte. The output enable is low for at least one clock before RE# falls.
- R7: A request is taken only while `acc_ready` is high. `busy` stays high from the cycle after acceptance until the last tail clock ends. A request held during a busy period starts no cycle and changes nothing about the cycle in progress.
- R8: An access at any other offset starts no bus cycle and leaves `busy` low. This covers reads of the command or address port and all offsets other than 0x00, 0x04 and 0x08.
- R9: `status[31]` follows `nand_rb` (1 = ready) two clocks after a change, and `status[30:0]` reads zero.
- R10: The timing words are captured at acceptance. Changing them while busy does not change the phase lengths of the cycle in progress.
- R11: While reset is applied, and at the end of it: WE#, RE# and all CE# are high, CLE, ALE, the output enable and `busy` are low, and `acc_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; one tick per period |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_valid | input | 1 | Host request strobe |
| acc_write | input | 1 | 1 = write access, 0 = read access |
| acc_addr | input | 10 | [9:8] chip select, [7:0] port offset |
| acc_wdata | input | 8 | Byte for command, address or data write |
| acc_ready | output | 1 | Engine idle, request will be taken |
| busy | output | 1 | Bus cycle in progress |
| rd_data | output | 8 | Last byte captured from a data read |
| rd_valid | output | 1 | One-clock pulse when `rd_data` updates |
| wr_timing | input | 32 | Write timing word (setup, extension, cycle, strobe) |
| rd_timing | input | 32 | Read timing word (access, hold, unused, release) |
| nand_cle | output | 1 | Command latch enable |
| nand_ale | output | 1 | Address latch enable |
| nand_we_n | output | 1 | Write strobe, active low |
| nand_re_n | output | 1 | Read strobe, active low |
| nand_ce_n | output | 4 | Chip enables, active low |
| nand_dq_out | output | 8 | Data bus output value |
| nand_dq_oe | output | 1 | Data bus output enable |
| nand_dq_in | input | 8 | Data bus input value |
| nand_rb | input | 1 | Flash ready/busy pin, 1 = ready |
| status | output | 32 | Bit 31 = synchronized ready, others zero |

## Verification
The hardest thing to pin down from the ports is the clock on which a read byte is captured. The flash model drives a constant level, so any capture clock inside the strobe window would give the same byte. To expose the capture clock, the bench changes `nand_dq_in` on every clock while RE# is low, giving it a value that counts the strobe clocks. The byte that comes back therefore shows exactly which strobe clock was sampled. A second hard case is a request held high across a whole busy period. The bench keeps `acc_valid` asserted with a different chip select and offset from acceptance to the end of the cycle. It then checks that only one strobe pulse appeared, on the first chip enable, and that the block stays idle afterwards.

// File: rtl/nand_cg_pkg.sv
package nand_cg_pkg;

    typedef enum logic [2:0] {
        PH_IDLE   = 3'd0,
        PH_SETUP  = 3'd1,
        PH_STROBE = 3'd2,
        PH_RECOV  = 3'd3,
        PH_TAIL   = 3'd4
    } phase_e;

    typedef enum logic [1:0] {
        K_CMD  = 2'd0,
        K_ADDR = 2'd1,
        K_DWR  = 2'd2,
        K_DRD  = 2'd3
    } kind_e;

endpackage

// File: rtl/nand_cg_decode.sv
module nand_cg_decode
    import nand_cg_pkg::*;
#(
    parameter int WIN_W   = 8,
    parameter int SEL_W   = 2,
    parameter int CMD_OFS = 0,
    parameter int ADR_OFS = 4,
    parameter int DAT_OFS = 8,
    localparam int ADDR_W = WIN_W + SEL_W
) (
    input  logic              valid_i,
    input  logic              write_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              idle_i,
    output logic              start_o,
    output kind_e             kind_o,
    output logic [SEL_W-1:0]  sel_o
);
    logic [WIN_W-1:0] ofs;
    logic             hit;

    assign ofs   = addr_i[WIN_W-1:0];
    assign sel_o = addr_i[ADDR_W-1:WIN_W];

    always_comb begin
        hit    = 1'b0;
        kind_o = K_CMD;
        if (ofs == WIN_W'(CMD_OFS) && write_i) begin
            hit    = 1'b1;
            kind_o = K_CMD;
        end else if (ofs == WIN_W'(ADR_OFS) && write_i) begin
            hit    = 1'b1;
            kind_o = K_ADDR;
        end else if (ofs == WIN_W'(DAT_OFS)) begin
            hit    = 1'b1;
            kind_o = write_i ? K_DWR : K_DRD;
        end
    end

    assign start_o = valid_i && idle_i && hit;

endmodule

// File: rtl/nand_cg_sync.sv
module nand_cg_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    output logic sync_o
);
    logic [STAGES-1:0] chain_q;

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain_q[0] <= 1'b0;
                    else        chain_q[0] <= async_i;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain_q[s] <= 1'b0;
                    else        chain_q[s] <= chain_q[s-1];
                end
            end
        end
    endgenerate

    assign sync_o = chain_q[STAGES-1];

endmodule

// File: rtl/nand_cg_engine.sv
module nand_cg_engine
    import nand_cg_pkg::*;
#(
    parameter int SEL_W  = 2,
    parameter int DATA_W = 8,
    parameter int TICK_W = 8,
    localparam int WORD_W = 4 * TICK_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  kind_e             kind_i,
    input  logic [SEL_W-1:0]  sel_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic [WORD_W-1:0] wr_timing_i,
    input  logic [WORD_W-1:0] rd_timing_i,
    input  logic [DATA_W-1:0] dq_in_i,
    output phase_e            phase_o,
    output kind_e             kind_o,
    output logic [SEL_W-1:0]  sel_o,
    output logic [DATA_W-1:0] wdata_o,
    output logic [DATA_W-1:0] rdata_o,
    output logic              rvalid_o
);
    typedef struct packed {
        phase_e            ph;
        kind_e             kind;
        logic [SEL_W-1:0]  sel;
        logic [DATA_W-1:0] wd;
        logic [DATA_W-1:0] rd;
        logic              rv;
        logic [TICK_W-1:0] cnt;
        logic [TICK_W-1:0] len_strobe;
        logic [TICK_W-1:0] len_recov;
        logic [TICK_W-1:0] len_tail;
    } eng_t;

    eng_t st_d, st_q;

    // field extraction: byte 3 is the most significant
    function automatic logic [TICK_W-1:0] fld(input logic [WORD_W-1:0] w, input int idx);
        return w[idx*TICK_W +: TICK_W];
    endfunction

    function automatic logic [TICK_W-1:0] at_least_one(input logic [TICK_W-1:0] v);
        return (v == '0) ? TICK_W'(1) : v;
    endfunction

    logic [TICK_W-1:0] t_setup, t_ext, t_wcyc, t_wstr;
    logic [TICK_W-1:0] t_acc, t_hold, t_rel;
    logic [TICK_W-1:0] t_whigh;
    logic              rd_kind;

    always_comb begin
        t_setup = at_least_one(fld(wr_timing_i, 3));
        t_ext   = at_least_one(fld(wr_timing_i, 2));
        t_wcyc  = at_least_one(fld(wr_timing_i, 1));
        t_wstr  = at_least_one(fld(wr_timing_i, 0));
        t_acc   = at_least_one(fld(rd_timing_i, 3));
        t_hold  = at_least_one(fld(rd_timing_i, 2));
        t_rel   = at_least_one(fld(rd_timing_i, 0));
        t_whigh = (t_wcyc > t_wstr) ? (t_wcyc - t_wstr) : TICK_W'(1);
        rd_kind = (kind_i == K_DRD);
    end

    always_comb begin
        st_d    = st_q;
        st_d.rv = 1'b0;
        unique case (st_q.ph)
            PH_IDLE: begin
                if (start_i) begin
                    st_d.ph         = PH_SETUP;
                    st_d.kind       = kind_i;
                    st_d.sel        = sel_i;
                    st_d.wd         = wdata_i;
                    st_d.cnt        = t_setup - TICK_W'(1);
                    st_d.len_strobe = rd_kind ? t_acc  : t_wstr;
                    st_d.len_recov  = rd_kind ? t_hold : t_whigh;
                    st_d.len_tail   = rd_kind ? t_rel  : t_ext;
                end
            end
            PH_SETUP: begin
                if (st_q.cnt == '0) begin
                    st_d.ph  = PH_STROBE;
                    st_d.cnt = st_q.len_strobe - TICK_W'(1);
                end else begin
                    st_d.cnt = st_q.cnt - TICK_W'(1);
                end
            end
            PH_STROBE: begin
                if (st_q.cnt == '0) begin
                    st_d.ph  = PH_RECOV;
                    st_d.cnt = st_q.len_recov - TICK_W'(1);
                    if (st_q.kind == K_DRD) begin
                        st_d.rd = dq_in_i;
                        st_d.rv = 1'b1;
                    end
                end else begin
                    st_d.cnt = st_q.cnt - TICK_W'(1);
                end
            end
            PH_RECOV: begin
                if (st_q.cnt == '0) begin
                    st_d.ph  = PH_TAIL;
                    st_d.cnt = st_q.len_tail - TICK_W'(1);
                end else begin
                    st_d.cnt = st_q.cnt - TICK_W'(1);
                end
            end
            PH_TAIL: begin
                if (st_q.cnt == '0) begin
                    st_d.ph = PH_IDLE;
                end else begin
                    st_d.cnt = st_q.cnt - TICK_W'(1);
                end
            end
            default: st_d.ph = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.ph         <= PH_IDLE;
            st_q.kind       <= K_CMD;
            st_q.sel        <= '0;
            st_q.wd         <= '0;
            st_q.rd         <= '0;
            st_q.rv         <= 1'b0;
            st_q.cnt        <= '0;
            st_q.len_strobe <= '0;
            st_q.len_recov  <= '0;
            st_q.len_tail   <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign phase_o  = st_q.ph;
    assign kind_o   = st_q.kind;
    assign sel_o    = st_q.sel;
    assign wdata_o  = st_q.wd;
    assign rdata_o  = st_q.rd;
    assign rvalid_o = st_q.rv;

endmodule

// File: rtl/nand_cg_pins.sv
module nand_cg_pins
    import nand_cg_pkg::*;
#(
    parameter int SEL_W  = 2,
    parameter int DATA_W = 8,
    localparam int NUM_CS = 1 << SEL_W
) (
    input  phase_e            phase_i,
    input  kind_e             kind_i,
    input  logic [SEL_W-1:0]  sel_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic              cle_o,
    output logic              ale_o,
    output logic              we_n_o,
    output logic              re_n_o,
    output logic [NUM_CS-1:0] ce_n_o,
    output logic [DATA_W-1:0] dq_out_o,
    output logic              dq_oe_o,
    output logic              busy_o
);
    logic active, strobe, is_read;

    assign active  = (phase_i != PH_IDLE);
    assign strobe  = (phase_i == PH_STROBE);
    assign is_read = (kind_i == K_DRD);

    assign cle_o    = active && (kind_i == K_CMD);
    assign ale_o    = active && (kind_i == K_ADDR);
    assign we_n_o   = !(strobe && !is_read);
    assign re_n_o   = !(strobe && is_read);
    assign dq_oe_o  = active && !is_read;
    assign dq_out_o = wdata_i;
    assign busy_o   = active;

    generate
        for (genvar i = 0; i < NUM_CS; i++) begin : g_ce
            assign ce_n_o[i] = !(active && (sel_i == SEL_W'(i)));
        end
    endgenerate

endmodule

// File: rtl/nand_cycle_gen.sv
module nand_cycle_gen
    import nand_cg_pkg::*;
#(
    parameter int SEL_W       = 2,
    parameter int WIN_W       = 8,
    parameter int DATA_W      = 8,
    parameter int TICK_W      = 8,
    parameter int SYNC_STAGES = 2,
    localparam int NUM_CS = 1 << SEL_W,
    localparam int ADDR_W = WIN_W + SEL_W,
    localparam int WORD_W = 4 * TICK_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_valid,
    input  logic              acc_write,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic [DATA_W-1:0] acc_wdata,
    output logic              acc_ready,
    output logic              busy,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_valid,
    input  logic [WORD_W-1:0] wr_timing,
    input  logic [WORD_W-1:0] rd_timing,
    output logic              nand_cle,
    output logic              nand_ale,
    output logic              nand_we_n,
    output logic              nand_re_n,
    output logic [NUM_CS-1:0] nand_ce_n,
    output logic [DATA_W-1:0] nand_dq_out,
    output logic              nand_dq_oe,
    input  logic [DATA_W-1:0] nand_dq_in,
    input  logic              nand_rb,
    output logic [31:0]       status
);
    logic              start;
    kind_e             dec_kind, eng_kind;
    logic [SEL_W-1:0]  dec_sel, eng_sel;
    phase_e            eng_phase;
    logic [DATA_W-1:0] eng_wd;
    logic              rb_sync;

    assign acc_ready = (eng_phase == PH_IDLE);

    nand_cg_decode #(.WIN_W(WIN_W), .SEL_W(SEL_W)) u_decode (
        .valid_i (acc_valid),
        .write_i (acc_write),
        .addr_i  (acc_addr),
        .idle_i  (acc_ready),
        .start_o (start),
        .kind_o  (dec_kind),
        .sel_o   (dec_sel)
    );

    nand_cg_engine #(.SEL_W(SEL_W), .DATA_W(DATA_W), .TICK_W(TICK_W)) u_engine (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (start),
        .kind_i      (dec_kind),
        .sel_i       (dec_sel),
        .wdata_i     (acc_wdata),
        .wr_timing_i (wr_timing),
        .rd_timing_i (rd_timing),
        .dq_in_i     (nand_dq_in),
        .phase_o     (eng_phase),
        .kind_o      (eng_kind),
        .sel_o       (eng_sel),
        .wdata_o     (eng_wd),
        .rdata_o     (rd_data),
        .rvalid_o    (rd_valid)
    );

    nand_cg_pins #(.SEL_W(SEL_W), .DATA_W(DATA_W)) u_pins (
        .phase_i  (eng_phase),
        .kind_i   (eng_kind),
        .sel_i    (eng_sel),
        .wdata_i  (eng_wd),
        .cle_o    (nand_cle),
        .ale_o    (nand_ale),
        .we_n_o   (nand_we_n),
        .re_n_o   (nand_re_n),
        .ce_n_o   (nand_ce_n),
        .dq_out_o (nand_dq_out),
        .dq_oe_o  (nand_dq_oe),
        .busy_o   (busy)
    );

    nand_cg_sync #(.STAGES(SYNC_STAGES)) u_rb_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (nand_rb),
        .sync_o  (rb_sync)
    );

    assign status = {rb_sync, 31'b0};

endmodule

// File: rtl/nand_cycle_gen_chk.sv
module nand_cycle_gen_chk #(
    parameter int NUM_CS = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              acc_valid,
    input logic              busy,
    input logic              rd_valid,
    input logic              nand_cle,
    input logic              nand_ale,
    input logic              nand_we_n,
    input logic              nand_re_n,
    input logic [NUM_CS-1:0] nand_ce_n,
    input logic              nand_dq_oe
);
    assert_cle_ale_excl_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !(nand_cle && nand_ale));

    assert_one_ce_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~nand_ce_n));

    assert_rvalid_after_re_R4: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> $past(!nand_re_n));

    assert_oe_off_before_re_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(nand_re_n) |-> $past(!nand_dq_oe));

    assert_oe_re_excl_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !(nand_dq_oe && !nand_re_n));

    assert_busy_from_req_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(acc_valid));

    assert_idle_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (nand_we_n && nand_re_n && (&nand_ce_n) && !nand_dq_oe));

endmodule

bind nand_cycle_gen nand_cycle_gen_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .acc_valid  (acc_valid),
    .busy       (busy),
    .rd_valid   (rd_valid),
    .nand_cle   (nand_cle),
    .nand_ale   (nand_ale),
    .nand_we_n  (nand_we_n),
    .nand_re_n  (nand_re_n),
    .nand_ce_n  (nand_ce_n),
    .nand_dq_oe (nand_dq_oe)
);

// File: tb/nand_cycle_gen_bench.sv
module nand_cycle_gen_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        acc_valid = 1'b0;
    logic        acc_write = 1'b0;
    logic [9:0]  acc_addr = '0;
    logic [7:0]  acc_wdata = '0;
    logic        acc_ready, busy, rd_valid;
    logic [7:0]  rd_data;
    logic [31:0] wr_timing = '0;
    logic [31:0] rd_timing = '0;
    logic        nand_cle, nand_ale, nand_we_n, nand_re_n, nand_dq_oe;
    logic [3:0]  nand_ce_n;
    logic [7:0]  nand_dq_out;
    logic [7:0]  nand_dq_in = '0;
    logic        nand_rb = 1'b1;
    logic [31:0] status;

    int nchk = 0;
    int nfail = 0;

    always #5 clk = ~clk;

    nand_cycle_gen u_nand_cycle_gen (
        .clk(clk), .rst_n(rst_n),
        .acc_valid(acc_valid), .acc_write(acc_write), .acc_addr(acc_addr),
        .acc_wdata(acc_wdata), .acc_ready(acc_ready), .busy(busy),
        .rd_data(rd_data), .rd_valid(rd_valid),
        .wr_timing(wr_timing), .rd_timing(rd_timing),
        .nand_cle(nand_cle), .nand_ale(nand_ale), .nand_we_n(nand_we_n),
        .nand_re_n(nand_re_n), .nand_ce_n(nand_ce_n), .nand_dq_out(nand_dq_out),
        .nand_dq_oe(nand_dq_oe), .nand_dq_in(nand_dq_in), .nand_rb(nand_rb),
        .status(status)
    );

    // observations of one access
    int         m_pre, m_str, m_post, m_pulses, m_rv;
    logic       m_cle, m_ale, m_oe_str, m_oe_any;
    logic [3:0] m_ce;
    logic [7:0] m_dout;

    task automatic chk(input string what, input int act, input int exp);
        nchk++;
        if (act != exp) begin
            nfail++;
            $display("FAIL %s: actual %0d expected %0d", what, act, exp);
        end
    endtask

    task automatic issue(input logic w, input logic [9:0] a, input logic [7:0] d);
        acc_valid = 1'b1;
        acc_write = w;
        acc_addr  = a;
        acc_wdata = d;
        @(posedge clk);
        @(negedge clk);
        acc_valid = 1'b0;
    endtask

    // called on the negedge right after acceptance; returns on the first idle negedge
    task automatic monitor(input logic [7:0] base);
        bit seen = 0;
        bit prev = 0;
        int guard = 0;
        m_pre = 0; m_str = 0; m_post = 0; m_pulses = 0; m_rv = 0;
        m_cle = 0; m_ale = 0; m_oe_str = 0; m_oe_any = 0; m_ce = 4'hF; m_dout = '0;
        while (busy && guard < 5000) begin
            bit strb;
            strb = !nand_we_n || !nand_re_n;
            if (rd_valid) m_rv++;
            if (nand_dq_oe) m_oe_any = 1;
            if (strb) begin
                if (!prev) m_pulses++;
                m_cle = nand_cle; m_ale = nand_ale; m_ce = nand_ce_n;
                m_dout = nand_dq_out; m_oe_str = nand_dq_oe;
                if (!nand_re_n) nand_dq_in = base + 8'(m_str);
                m_str++;
                seen = 1;
            end else if (!seen) begin
                m_pre++;
            end else begin
                m_post++;
            end
            prev = strb;
            guard++;
            @(negedge clk);
        end
        if (rd_valid) m_rv++;
    endtask

    task automatic t_reset;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk("R11 we_n in reset", nand_we_n, 1);
        chk("R11 ce_n in reset", nand_ce_n, 15);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R11 re_n after reset", nand_re_n, 1);
        chk("R11 busy/oe/cle/ale after reset", {busy, nand_dq_oe, nand_cle, nand_ale}, 0);
        chk("R11 acc_ready after reset", acc_ready, 1);
    endtask

    task automatic t_cmd_write;
        wr_timing = {8'd3, 8'd4, 8'd6, 8'd2};
        issue(1'b1, 10'h100, 8'hA5);
        monitor(8'h00);
        chk("R3 cmd setup clocks", m_pre, 3);
        chk("R3 cmd WE# low clocks", m_str, 2);
        chk("R3 cmd high+extension clocks", m_post, 8);
        chk("R1 cmd CLE/ALE", {m_cle, m_ale}, 2'b10);
        chk("R2 cmd ce_n select 1", m_ce, 4'b1101);
        chk("R6 cmd data value", m_dout, 8'hA5);
        chk("R6 cmd oe during strobe", m_oe_str, 1);
    endtask

    task automatic t_addr_write;
        wr_timing = {8'd1, 8'd2, 8'd2, 8'd5};
        issue(1'b1, 10'h304, 8'h3C);
        monitor(8'h00);
        chk("R3 addr setup clocks", m_pre, 1);
        chk("R3 addr WE# low clocks", m_str, 5);
        chk("R3 addr short cycle high+extension", m_post, 3);
        chk("R1 addr CLE/ALE", {m_cle, m_ale}, 2'b01);
        chk("R2 addr ce_n select 3", m_ce, 4'b0111);
    endtask

    task automatic t_data_write;
        wr_timing = {8'd2, 8'd1, 8'd4, 8'd3};
        issue(1'b1, 10'h008, 8'h5A);
        monitor(8'h00);
        chk("R1 data write CLE/ALE", {m_cle, m_ale}, 2'b00);
        chk("R2 data write ce_n select 0", m_ce, 4'b1110);
        chk("R6 data write value", m_dout, 8'h5A);
        chk("R3 data write total", m_pre + m_str + m_post, 2 + 3 + 1 + 1);
    endtask

    task automatic t_data_read;
        wr_timing = {8'd2, 8'd9, 8'd9, 8'd9};
        rd_timing = {8'd4, 8'd3, 8'd9, 8'd2};
        issue(1'b0, 10'h208, 8'h00);
        monitor(8'h40);
        chk("R4 read setup clocks", m_pre, 2);
        chk("R4 read RE# low clocks", m_str, 4);
        chk("R4 read hold+release clocks", m_post, 5);
        chk("R4 read capture on last strobe clock", rd_data, 8'h43);
        chk("R4 read valid pulses", m_rv, 1);
        chk("R6 read oe never high", m_oe_any, 0);
        chk("R1 read CLE/ALE", {m_cle, m_ale}, 2'b00);
        chk("R2 read ce_n select 2", m_ce, 4'b1011);
    endtask

    task automatic t_zero_fields;
        wr_timing = '0;
        rd_timing = '0;
        issue(1'b1, 10'h000, 8'h11);
        monitor(8'h00);
        chk("R5 zero write phases", m_pre * 100 + m_str * 10 + m_post, 112);
        issue(1'b0, 10'h108, 8'h00);
        monitor(8'h70);
        chk("R5 zero read phases", m_pre * 100 + m_str * 10 + m_post, 112);
        chk("R5 zero read capture", rd_data, 8'h70);
    endtask

    task automatic t_busy_ignore;
        wr_timing = {8'd2, 8'd3, 8'd5, 8'd2};
        acc_valid = 1'b1; acc_write = 1'b1; acc_addr = 10'h100; acc_wdata = 8'h77;
        @(posedge clk);
        @(negedge clk);
        acc_addr = 10'h004; acc_wdata = 8'h99;
        monitor(8'h00);
        acc_valid = 1'b0;
        chk("R7 single strobe pulse while held", m_pulses, 1);
        chk("R7 first select kept", m_ce, 4'b1101);
        chk("R7 first data kept", m_dout, 8'h77);
        chk("R7 busy length", m_pre + m_str + m_post, 2 + 2 + 3 + 3);
        repeat (3) @(negedge clk);
        chk("R7 stays idle after held request", busy, 0);
    endtask

    task automatic t_unmapped;
        int bad = 0;
        issue(1'b1, 10'h010, 8'h12);
        chk("R8 write to unmapped offset", busy, 0);
        issue(1'b0, 10'h000, 8'h00);
        chk("R8 read of command port", busy, 0);
        issue(1'b0, 10'h304, 8'h00);
        chk("R8 read of address port", busy, 0);
        repeat (3) begin
            if (!nand_we_n || !nand_re_n || nand_ce_n != 4'hF) bad++;
            @(negedge clk);
        end
        chk("R8 no strobe after unmapped", bad, 0);
    endtask

    task automatic t_latch;
        wr_timing = {8'd2, 8'd2, 8'd4, 8'd3};
        issue(1'b1, 10'h000, 8'h21);
        wr_timing = {8'd7, 8'd7, 8'd9, 8'd6};
        monitor(8'h00);
        chk("R10 setup from captured word", m_pre, 2);
        chk("R10 strobe from captured word", m_str, 3);
        chk("R10 tail from captured word", m_post, 3);
    endtask

    task automatic t_status;
        nand_rb = 1'b0;
        @(negedge clk);
        chk("R9 status holds one clock", status[31], 1);
        @(negedge clk);
        chk("R9 status shows busy", status[31], 0);
        nand_rb = 1'b1;
        @(negedge clk);
        @(negedge clk);
        chk("R9 status shows ready", status[31], 1);
        chk("R9 status low bits zero", int'(status[30:0] != 0), 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        nfail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

    initial begin
        @(negedge clk);
        t_reset();
        t_cmd_write();
        t_addr_write();
        t_data_write();
        t_data_read();
        t_zero_fields();
        t_busy_ignore();
        t_unmapped();
        t_latch();
        t_status();
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

endmodule